// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Timer Channel

This block is one channel of a timer that runs beside a 16-bit free-running counter. The counter lives outside the block. One holding register and one port pin are shared between two functions, and a mode bit in a small configuration register chooses between them.

In input-capture mode, the channel watches the pin for the edges chosen by a select field. It copies the counter value into the holding register on each such edge and raises a status flag. In output-compare mode, the channel compares the counter with the holding register. On a match it sets the same flag and applies a chosen action to the pin.

A direction bit turns the pin into an output. The pin is then driven from an output-data latch. With the pin set as an output in capture mode, software writes to that latch cause edges, and those edges are captured in the same way as external edges. An interrupt is raised while the flag and its mask bit are both set.

A three-state controller sequences the work:
- `ST_COMPARE` is the reset state and stands for output-compare mode.
- `ST_CAP_WAIT` is capture mode with no edge pending.
- `ST_CAP_LATCH` is the one-cycle latching slot that follows a qualified edge.

The transitions are:
- `ST_COMPARE`→`ST_CAP_WAIT` when the mode bit is set.
- `ST_CAP_WAIT`→`ST_CAP_LATCH` on a qualified edge.
- `ST_CAP_WAIT`→`ST_COMPARE` when the mode bit is cleared.
- `ST_CAP_LATCH`→`ST_CAP_LATCH` on a further qualified edge.
- `ST_CAP_LATCH`→`ST_CAP_WAIT` otherwise.
- `ST_CAP_LATCH`→`ST_COMPARE` when the mode bit is cleared.

Top module: `tmr_chan_top`

## Requirements
- R1: After reset, the hold register reads 0xFFFF. The flag, the interrupt, the pin output and the pin output enable are 0. The configuration register reads 0, which means compare mode, pin as input, edges disabled, no compare action and interrupt masked.
- R2: The configuration word is 7 bits, from MSB to LSB: mode (1 = capture), direction (1 = output), edge select [1:0], compare action [1:0], interrupt mask. It is written with `cfg_we_i` and reads back on `cfg_rd_o`.
- R3: In capture mode, a qualified edge on the pin, sampled at rising clock edge k, loads the hold register with the `cnt_i` value present between clock edges k+2 and k+3. The new value is visible after edge k+3.
- R4: Edge select: 00 captures nothing, 01 captures rising edges only, 10 captures falling edges only, 11 captures both.
- R5: In capture mode, writes to the hold register are ignored.
- R6: With direction = 1 in capture mode, a write to the output data that changes `pin_o` is captured one cycle later than an external edge: the value is `cnt_i` between edges k+3 and k+4 when the write is sampled at edge k. Changes on `pin_i` are then ignored.
- R7: In compare mode, if `cnt_i` equals the hold register when sampled at edge j, then at edge j+1 the pin takes the action and the flag sets. The action codes are 00 none, 01 toggle, 10 clear and 11 set.
- R8: Each capture or compare match sets the flag. Writing `flag_clr_i` = 1 clears it. `irq_o` is high exactly while the flag and the mask are both 1.
- R9: In compare mode, pin edges cause no capture and leave the flag unchanged, and hold-register writes take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Free-running counter value |
| pin_i | input | 1 | Pin level from the pad |
| pin_o | output | 1 | Pin output data |
| pin_oe_o | output | 1 | Pin output enable (direction bit) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wd_i | input | 7 | Configuration write data |
| cfg_rd_o | output | 7 | Configuration read-back |
| hold_we_i | input | 1 | Hold-register write strobe |
| hold_wd_i | input | 16 | Hold-register write data |
| hold_rd_o | output | 16 | Hold-register read data |
| dat_we_i | input | 1 | Output-data write strobe |
| dat_wd_i | input | 1 | Output-data write value |
| flag_clr_i | input | 1 | Write-1-to-clear of the flag |
| flag_o | output | 1 | Capture/compare status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims first at the capture timing. A design with one synchronizer stage too many or too few, or with the latch slot dropped, stores a counter value off by one. Each edge-select code is tried with both polarities, so a swapped rise/fall decode shows up as a missing or unexpected capture.

Hold writes during capture mode are checked, because a design that lets them through loses the captured time. So are self-triggered captures through the output latch, which a design that ignores the direction bit would miss.

In compare mode, each of the four actions is timed exactly one cycle after the match. A wrong action encoding or an unsynchronised match moves the pin in the wrong cycle. The test also confirms that pin edges are ignored in that mode.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ST_COMPARE   = 2'd0,
        ST_CAP_WAIT  = 2'd1,
        ST_CAP_LATCH = 2'd2
    } chan_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } pin_act_e;

    // Configuration word: mode, direction, edge select, action, mask
    typedef struct packed {
        logic       mode_cap;
        logic       dir_out;
        logic [1:0] edge_sel;
        logic [1:0] act_sel;
        logic       irq_mask;
    } chan_cfg_t;

    localparam int unsigned CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Synchronizer chain, one flop per stage
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q[0] <= 1'b0;
                else         sync_q[0] <= din_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q[i] <= 1'b0;
                else         sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Registered previous value for the edge compare
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= sync_q[LAST];
    end

    assign rise_o = sync_q[LAST] & ~prev_q;
    assign fall_o = ~sync_q[LAST] & prev_q;

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o})); // R4

endmodule

// File: rtl/tmr_chan_fsm.sv
module tmr_chan_fsm
    import tmr_chan_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mode_cap_i,
    input  logic [1:0] edge_sel_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       cap_mode_o,
    output logic       cap_latch_o
);
    chan_state_e state_q, state_d;
    logic        edge_hit;

    // Edge qualification: bit 0 enables rising, bit 1 enables falling
    assign edge_hit = (rise_i & edge_sel_i[0]) | (fall_i & edge_sel_i[1]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_COMPARE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COMPARE: begin
                if (mode_cap_i) state_d = ST_CAP_WAIT;
            end
            ST_CAP_WAIT: begin
                if (!mode_cap_i)   state_d = ST_COMPARE;
                else if (edge_hit) state_d = ST_CAP_LATCH;
            end
            ST_CAP_LATCH: begin
                if (!mode_cap_i)   state_d = ST_COMPARE;
                else if (edge_hit) state_d = ST_CAP_LATCH;
                else               state_d = ST_CAP_WAIT;
            end
            default: state_d = ST_COMPARE;
        endcase
    end

    always_comb begin
        cap_mode_o  = 1'b0;
        cap_latch_o = 1'b0;
        unique case (state_q)
            ST_COMPARE:   ;
            ST_CAP_WAIT:  cap_mode_o = 1'b1;
            ST_CAP_LATCH: begin
                cap_mode_o  = 1'b1;
                cap_latch_o = 1'b1;
            end
            default: ;
        endcase
    end

    AST_LATCH_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CAP_LATCH) |-> $past(rise_i | fall_i)); // R3

    AST_NO_LATCH_IN_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_cap_i |=> (state_q == ST_COMPARE)); // R9

endmodule

// File: rtl/tmr_hold_unit.sv
module tmr_hold_unit
    import tmr_chan_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cap_mode_i,
    input  logic             cap_latch_i,
    input  logic             hold_we_i,
    input  logic [CNT_W-1:0] hold_wd_i,
    input  logic [1:0]       act_sel_i,
    input  logic             dat_we_i,
    input  logic             dat_wd_i,
    input  logic             flag_clr_i,
    input  logic             mask_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             pin_out_o,
    output logic             flag_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] HOLD_RST = '1;

    logic [CNT_W-1:0] hold_q;
    logic             cmp_hit_q;
    logic             pin_q;
    logic             flag_q;
    logic             cmp_event;
    pin_act_e         act;

    assign act       = pin_act_e'(act_sel_i);
    assign cmp_event = cmp_hit_q & ~cap_mode_i;

    // Shared holding register: capture latch or software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     hold_q <= HOLD_RST;
        else if (cap_latch_i)            hold_q <= cnt_i;
        else if (!cap_mode_i && hold_we_i) hold_q <= hold_wd_i;
    end

    // Match registered once: pin acts one cycle after the match
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmp_hit_q <= 1'b0;
        else         cmp_hit_q <= ~cap_mode_i & (cnt_i == hold_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_q <= 1'b0;
        end else if (cmp_event && act != ACT_NONE) begin
            unique case (act)
                ACT_TOGGLE: pin_q <= ~pin_q;
                ACT_CLEAR:  pin_q <= 1'b0;
                ACT_SET:    pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end else if (dat_we_i) begin
            pin_q <= dat_wd_i;
        end
    end

    // Flag: set wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      flag_q <= 1'b0;
        else if (cap_latch_i || cmp_event) flag_q <= 1'b1;
        else if (flag_clr_i)              flag_q <= 1'b0;
    end

    assign hold_o    = hold_q;
    assign pin_out_o = pin_q;
    assign flag_o    = flag_q;
    assign irq_o     = flag_q & mask_i;

    AST_HOLD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_mode_i && !cap_latch_i) |=> $stable(hold_q)); // R5

    AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_q) |-> $past(cap_latch_i || cmp_event)); // R8

    AST_PIN_QUIET_IN_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_mode_i && !dat_we_i) |=> $stable(pin_q)); // R7

endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_chan_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wd_i,
    output logic [CFG_W-1:0] cfg_rd_o,
    input  logic             hold_we_i,
    input  logic [CNT_W-1:0] hold_wd_i,
    output logic [CNT_W-1:0] hold_rd_o,
    input  logic             dat_we_i,
    input  logic             dat_wd_i,
    input  logic             flag_clr_i,
    output logic             flag_o,
    output logic             irq_o
);
    chan_cfg_t cfg_q;
    logic      pin_out;
    logic      pin_eff;
    logic      rise, fall;
    logic      cap_mode, cap_latch;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cfg_q <= '0;
        else if (cfg_we_i) cfg_q <= chan_cfg_t'(cfg_wd_i);
    end

    // An output pin feeds back its own driven level into capture
    assign pin_eff = cfg_q.dir_out ? pin_out : pin_i;

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (pin_eff),
        .rise_o (rise),
        .fall_o (fall)
    );

    tmr_chan_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_cap_i  (cfg_q.mode_cap),
        .edge_sel_i  (cfg_q.edge_sel),
        .rise_i      (rise),
        .fall_i      (fall),
        .cap_mode_o  (cap_mode),
        .cap_latch_o (cap_latch)
    );

    tmr_hold_unit #(.CNT_W(CNT_W)) u_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_i       (cnt_i),
        .cap_mode_i  (cap_mode),
        .cap_latch_i (cap_latch),
        .hold_we_i   (hold_we_i),
        .hold_wd_i   (hold_wd_i),
        .act_sel_i   (cfg_q.act_sel),
        .dat_we_i    (dat_we_i),
        .dat_wd_i    (dat_wd_i),
        .flag_clr_i  (flag_clr_i),
        .mask_i      (cfg_q.irq_mask),
        .hold_o      (hold_rd_o),
        .pin_out_o   (pin_out),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );

    assign pin_o    = pin_out;
    assign pin_oe_o = cfg_q.dir_out;
    assign cfg_rd_o = cfg_q;

    AST_CFG_RESET_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pin_oe_o) |-> $past(cfg_we_i)); // R2

endmodule

// File: tb/tmr_chan_top_bench.sv
`timescale 1ns/1ps
module tmr_chan_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic        pin_i = 1'b0;
    logic        pin_o, pin_oe;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wd = '0;
    logic [6:0]  cfg_rd;
    logic        hold_we = 1'b0;
    logic [15:0] hold_wd = '0;
    logic [15:0] hold_rd;
    logic        dat_we = 1'b0;
    logic        dat_wd = 1'b0;
    logic        flag_clr = 1'b0;
    logic        flag, irq;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    bit          mon_en = 1'b0;
    logic [15:0] last_hold = 16'hFFFF;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= 16'(cnt + 16'd1);
    end

    tmr_chan_top u_tmr_chan_top (
        .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe),
        .cfg_we_i(cfg_we), .cfg_wd_i(cfg_wd), .cfg_rd_o(cfg_rd),
        .hold_we_i(hold_we), .hold_wd_i(hold_wd), .hold_rd_o(hold_rd),
        .dat_we_i(dat_we), .dat_wd_i(dat_wd), .flag_clr_i(flag_clr),
        .flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every change of the hold register in capture tests pops one expected value
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_en && hold_rd != last_hold) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected capture", hold_rd, last_hold);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(hold_rd == e, "R3 captured value", hold_rd, e);
                end
            end
            last_hold = hold_rd;
        end
    end

    task automatic cfg_write(input logic [6:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wd = w;
        @(negedge clk); cfg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hold_write(input logic [15:0] v);
        @(negedge clk); hold_we = 1'b1; hold_wd = v;
        @(negedge clk); hold_we = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // External edge: sampled at next rising edge k, value is cnt after edge k+2
    task automatic pin_drive(input logic v, input bit expect_cap);
        @(negedge clk); pin_i = v;
        if (expect_cap) exp_q.push_back(16'(cnt + 16'd3));
        repeat (6) @(negedge clk);
    endtask

    // Self-triggered edge through the output latch: one cycle later
    task automatic out_write(input logic v, input bit expect_cap);
        @(negedge clk); dat_we = 1'b1; dat_wd = v;
        if (expect_cap) exp_q.push_back(16'(cnt + 16'd4));
        @(negedge clk); dat_we = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, 16'(exp_q.size()), 16'd0);
    endtask

    task automatic cmp_case(input logic [1:0] act, input logic start_pin, input logic exp_pin);
        logic [15:0] h;
        cfg_write({1'b0, 1'b1, 2'b00, act, 1'b0});
        @(negedge clk); dat_we = 1'b1; dat_wd = start_pin;
        @(negedge clk); dat_we = 1'b0;
        clr_flag();
        h = 16'(cnt + 16'd10);
        hold_write(h);
        while (cnt != h) @(negedge clk);
        chk(pin_o == start_pin, "R7 pin before match", {15'd0, pin_o}, {15'd0, start_pin});
        @(negedge clk);
        chk(pin_o == start_pin, "R7 pin one cycle after match", {15'd0, pin_o}, {15'd0, start_pin});
        @(negedge clk);
        chk(pin_o == exp_pin, "R7 pin action", {15'd0, pin_o}, {15'd0, exp_pin});
        chk(flag == 1'b1, "R7 R8 flag on match", {15'd0, flag}, 16'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(hold_rd == 16'hFFFF, "R1 hold reset", hold_rd, 16'hFFFF);
        chk(flag == 1'b0 && irq == 1'b0, "R1 flag/irq reset", {14'd0, flag, irq}, 16'd0);
        chk(pin_o == 1'b0 && pin_oe == 1'b0, "R1 pin reset", {14'd0, pin_o, pin_oe}, 16'd0);
        chk(cfg_rd == 7'd0, "R1 cfg reset", {9'd0, cfg_rd}, 16'd0);

        // R2 configuration read-back, capture on rising only
        cfg_write(7'b1_0_01_00_0);
        chk(cfg_rd == 7'b1_0_01_00_0, "R2 cfg readback", {9'd0, cfg_rd}, 16'h0048);
        mon_en = 1'b1;

        // R4 edge select 01: rising only
        pin_drive(1'b1, 1'b1);
        pin_drive(1'b0, 1'b0);
        pin_drive(1'b1, 1'b1);
        pin_drive(1'b0, 1'b0);
        drained("R4 rising-only captures");

        // R4 edge select 10: falling only
        cfg_write(7'b1_0_10_00_0);
        pin_drive(1'b1, 1'b0);
        pin_drive(1'b0, 1'b1);
        drained("R4 falling-only captures");

        // R4 edge select 11: both
        cfg_write(7'b1_0_11_00_0);
        pin_drive(1'b1, 1'b1);
        pin_drive(1'b0, 1'b1);
        drained("R3 R4 both-edge captures");

        // R4 edge select 00: none
        cfg_write(7'b1_0_00_00_0);
        held = hold_rd;
        pin_drive(1'b1, 1'b0);
        pin_drive(1'b0, 1'b0);
        chk(hold_rd == held, "R4 disabled edges", hold_rd, held);

        // R5 writes ignored in capture mode
        held = hold_rd;
        hold_write(16'h1234);
        repeat (3) @(negedge clk);
        chk(hold_rd == held, "R5 hold write ignored", hold_rd, held);

        // R8 flag and interrupt masking
        chk(flag == 1'b1 && irq == 1'b0, "R8 flag set, masked", {14'd0, flag, irq}, 16'h0002);
        cfg_write(7'b1_0_11_00_1);
        chk(irq == 1'b1, "R8 irq unmasked", {15'd0, irq}, 16'd1);
        clr_flag();
        chk(flag == 1'b0 && irq == 1'b0, "R8 flag clear", {14'd0, flag, irq}, 16'd0);
        pin_drive(1'b1, 1'b1);
        chk(flag == 1'b1 && irq == 1'b1, "R8 flag after capture", {14'd0, flag, irq}, 16'h0003);
        pin_drive(1'b0, 1'b1);
        drained("R8 captures");

        // R6 output pin triggers its own captures
        cfg_write(7'b1_1_11_00_0);
        chk(pin_oe == 1'b1, "R6 pin output enable", {15'd0, pin_oe}, 16'd1);
        out_write(1'b1, 1'b1);
        out_write(1'b0, 1'b1);
        drained("R6 self-triggered captures");
        held = hold_rd;
        pin_drive(1'b1, 1'b0);
        pin_drive(1'b0, 1'b0);
        chk(hold_rd == held, "R6 pad ignored when output", hold_rd, held);

        // R9 compare mode: pad edges ignored, hold writes land
        mon_en = 1'b0;
        cfg_write(7'b0_0_11_00_0);
        clr_flag();
        held = hold_rd;
        pin_drive(1'b1, 1'b0);
        pin_drive(1'b0, 1'b0);
        chk(hold_rd == held, "R9 no capture in compare", hold_rd, held);
        chk(flag == 1'b0, "R9 flag untouched", {15'd0, flag}, 16'd0);
        hold_write(16'h7ABC);
        chk(hold_rd == 16'h7ABC, "R9 hold write in compare", hold_rd, 16'h7ABC);

        // R7 compare actions
        cmp_case(2'b01, 1'b0, 1'b1);
        cmp_case(2'b10, 1'b1, 1'b0);
        cmp_case(2'b11, 1'b0, 1'b1);
        cmp_case(2'b00, 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule